// File: doc/BRIEF.md
# One-Instruction Bit-Serial Controller

This block is a very small sequencing engine that has no opcode decoder and no program counter. It runs one fixed instruction forever. Each instruction takes two steps, and each step reads one byte from an internal 1024-byte program store. The first byte picks one of eight test lines and names one output bit and the value to write into it. The second byte is the destination slot. The tested line decides which of two destination bytes is read, so every instruction is a bit write combined with a two-way jump. Software never has an implicit "next address": both outcomes are always spelled out.

The program store address is formed from three parts: the 8-bit jump register, the phase bit and the one-bit flag. Each destination therefore owns a four-byte slot. Output bit 7 is a discard slot: writing to it is the way to code "no output this instruction". Output bits 5 and 6 are fed back internally as test lines 6 and 7. They are the only memory the program has, for example to choose the return path of a shared subroutine. While reset is held, reads come from a shadow pattern that means "write nothing, jump to slot 0".

The sequencer is a two-state machine. Reset enters state PH_ONE. On an enabled step, transition FETCH_OP moves PH_ONE to PH_TWO, writing the output bit and capturing the flag. On an enabled step, transition FETCH_DEST moves PH_TWO back to PH_ONE and loads the jump register. With `step` low the machine holds in either state. A program is preloaded through a simple byte write port.

Top module: `bitjump_ctrl`

## Requirements
- R1: After reset the machine is in PH_ONE. Each clock edge with `step` high moves PH_ONE to PH_TWO or PH_TWO to PH_ONE. A full instruction therefore takes exactly two enabled steps.
- R2: On an edge with `step` low and `rst` low, nothing changes: the phase, flag, jump register and `out_vec` keep their values.
- R3: The program store read address is {jump[7:0], phase, flag}. Phase is 0 in PH_ONE and 1 in PH_TWO. Slot s occupies bytes 4s..4s+3: 4s+0 and 4s+1 are the op byte for flag 0 and flag 1, and 4s+2 and 4s+3 are the destination for flag 0 and flag 1.
- R4: Op byte layout: bits 2:0 select the test line, bits 5:3 give the output bit index, bit 6 is the value to write, and bit 7 is ignored.
- R5: At the PH_ONE step edge, the flag takes the value of the selected test line and the indexed output bit takes the write value. No other output bit changes. `out_vec` never changes at a PH_TWO step edge.
- R6: At the PH_TWO step edge, the jump register loads the destination byte read at {jump, 1, flag}.
- R7: The flag keeps its value into the next PH_ONE. The op byte of the following instruction is therefore read from offset 0 or 1 according to the previous test result.
- R8: Output index 7 is a discard slot. A write to it, with either value, leaves `out_vec` unchanged, and `out_vec[7]` always reads 0.
- R9: Test lines 0..5 are `in_vec[5:0]`. Test line 6 is `out_vec[5]` and test line 7 is `out_vec[6]`. `in_vec[7:6]` have no effect.
- R10: A clock edge with `rst` high forces PH_ONE, jump 0, flag 0 and `out_vec` 0, whatever `step` is. While `rst` is high, reads return the shadow pattern: op byte 0x38 (write to the discard slot) and destination 0x00.
- R11: A clock edge with `rom_we` high stores `rom_wdata` at `rom_waddr`, independent of `step` and `rst`. A read at that same edge still sees the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Step-enable tick; the sequencer advances only when high |
| in_vec | input | 8 | External test lines (bits 7:6 ignored) |
| out_vec | output | 8 | Registered addressable output latch |
| rom_we | input | 1 | Program store write enable |
| rom_waddr | input | 10 | Program store write address |
| rom_wdata | input | 8 | Program store write data |

## Verification
An output write and a flag capture can fall in the same PH_ONE step when the op byte tests a feedback line (6 or 7) that the same byte writes. In that case the flag must take the feedback bit as it was before the write, not after. The near-exhaustive sweep runs random programs over the whole store with random inputs, random stalls, sporadic resets and stray store writes, so this self-test overlap occurs many times. Each cycle's `out_vec` is compared against a bench model that samples the test line before applying the write. Directed programs also pin down the loopback path, the flag-dependent op byte, the discard slot and the two-step timing.

// File: rtl/bjc_pkg.sv
package bjc_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_LINES = 8;
    localparam int OUT_W   = 8;
    localparam int SEL_W   = $clog2(N_LINES);
    localparam int IDX_W   = $clog2(OUT_W);
    localparam int ROM_AW  = BYTE_W + 2;
    localparam int ROM_DEPTH = 1 << ROM_AW;

    typedef enum logic {
        PH_ONE = 1'b0,
        PH_TWO = 1'b1
    } phase_t;

    // op byte: [7] spare, [6] value, [5:3] output index, [2:0] line select
    typedef struct packed {
        logic             spare;
        logic             val;
        logic [IDX_W-1:0] bit_sel;
        logic [SEL_W-1:0] line_sel;
    } op_t;

    localparam logic [IDX_W-1:0] DISCARD_IDX = IDX_W'(OUT_W - 1);

    localparam op_t SHADOW_OP = '{
        spare:    1'b0,
        val:      1'b0,
        bit_sel:  DISCARD_IDX,
        line_sel: '0
    };

    localparam logic [BYTE_W-1:0] SHADOW_DEST = '0;

    function automatic logic [BYTE_W-1:0] shadow_byte(input phase_t ph);
        logic [BYTE_W-1:0] b;
        unique case (ph)
            PH_ONE:  b = SHADOW_OP;
            PH_TWO:  b = SHADOW_DEST;
            default: b = SHADOW_DEST;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bjc_rom.sv
module bjc_rom #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    // R11: write at the edge, read is combinational (old byte at the write edge)
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bjc_tmux.sv
module bjc_tmux #(
    parameter int N_LINES = 8,
    parameter int SEL_W   = 3,
    parameter int OUT_W   = 8,
    parameter int FB_LO   = 5,
    parameter int FB_HI   = 6
) (
    input  logic [N_LINES-1:0] ext,
    input  logic [OUT_W-1:0]   fb,
    input  logic [SEL_W-1:0]   sel,
    output logic               line
);
    logic [N_LINES-1:0] lines;

    // R9: top two lines come back from the output latch
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        if (i == N_LINES - 2) begin : g_fb_lo
            assign lines[i] = fb[FB_LO];
        end else if (i == N_LINES - 1) begin : g_fb_hi
            assign lines[i] = fb[FB_HI];
        end else begin : g_ext
            assign lines[i] = ext[i];
        end
    end

    logic unused_tmux;
    assign unused_tmux = ^{ext[N_LINES-1:N_LINES-2], fb};

    assign line = lines[sel];

endmodule

// File: rtl/bjc_seq.sv
module bjc_seq
    import bjc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [BYTE_W-1:0] dest,
    input  logic              test_bit,
    output phase_t            ph,
    output logic [BYTE_W-1:0] jmp,
    output logic              flag,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              op_fire
);
    phase_t ph_nxt;

    // next-state: FETCH_OP (PH_ONE->PH_TWO), FETCH_DEST (PH_TWO->PH_ONE)
    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_ONE:  ph_nxt = PH_TWO;
            PH_TWO:  ph_nxt = PH_ONE;
            default: ph_nxt = PH_ONE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_ONE;
        end else if (step) begin
            ph <= ph_nxt;
        end
    end

    // flag and jump register
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            jmp  <= '0;
        end else if (step) begin
            unique case (ph)
                PH_ONE:  flag <= test_bit;
                PH_TWO:  jmp  <= dest;
                default: flag <= flag;
            endcase
        end
    end

    // outputs
    always_comb begin
        rom_addr = {jmp, 1'b0, flag};
        op_fire  = 1'b0;
        unique case (ph)
            PH_ONE: begin
                rom_addr = {jmp, 1'b0, flag};
                op_fire  = step && !rst;
            end
            PH_TWO: begin
                rom_addr = {jmp, 1'b1, flag};
                op_fire  = 1'b0;
            end
            default: begin
                rom_addr = {jmp, 1'b0, flag};
                op_fire  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bjc_olatch.sv
module bjc_olatch #(
    parameter int OUT_W   = 8,
    parameter int IDX_W   = 3,
    parameter int DISCARD = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    output logic [OUT_W-1:0] q
);
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i == DISCARD) begin : g_discard
            assign q[i] = 1'b0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[i] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    q[i] <= wr_val;
                end
            end
        end
    end

endmodule

// File: rtl/bitjump_ctrl.sv
module bitjump_ctrl
    import bjc_pkg::*;
#(
    parameter int FB_LO = 5,
    parameter int FB_HI = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [N_LINES-1:0] in_vec,
    output logic [OUT_W-1:0]   out_vec,
    input  logic               rom_we,
    input  logic [ROM_AW-1:0]  rom_waddr,
    input  logic [BYTE_W-1:0]  rom_wdata
);
    phase_t            phase_q;
    logic [BYTE_W-1:0] jmp_q;
    logic              flag_q;
    logic [ROM_AW-1:0] rom_raddr;
    logic [BYTE_W-1:0] rom_rdata;
    logic [BYTE_W-1:0] fetch_byte;
    logic              op_fire;
    logic              test_bit;
    op_t               op;

    bjc_rom #(.AW(ROM_AW), .DW(BYTE_W)) u_rom (
        .clk   (clk),
        .we    (rom_we),
        .waddr (rom_waddr),
        .wdata (rom_wdata),
        .raddr (rom_raddr),
        .rdata (rom_rdata)
    );

    // R10: shadow pattern while reset is held
    assign fetch_byte = rst ? shadow_byte(phase_q) : rom_rdata;
    assign op         = op_t'(fetch_byte);

    logic unused_spare;
    assign unused_spare = op.spare;

    bjc_tmux #(
        .N_LINES (N_LINES),
        .SEL_W   (SEL_W),
        .OUT_W   (OUT_W),
        .FB_LO   (FB_LO),
        .FB_HI   (FB_HI)
    ) u_tmux (
        .ext  (in_vec),
        .fb   (out_vec),
        .sel  (op.line_sel),
        .line (test_bit)
    );

    bjc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .dest     (fetch_byte),
        .test_bit (test_bit),
        .ph       (phase_q),
        .jmp      (jmp_q),
        .flag     (flag_q),
        .rom_addr (rom_raddr),
        .op_fire  (op_fire)
    );

    bjc_olatch #(
        .OUT_W   (OUT_W),
        .IDX_W   (IDX_W),
        .DISCARD (OUT_W - 1)
    ) u_olatch (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (op_fire),
        .wr_idx (op.bit_sel),
        .wr_val (op.val),
        .q      (out_vec)
    );

endmodule

// File: rtl/bjc_chk.sv
module bjc_chk
    import bjc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              step,
    input phase_t            ph,
    input logic [BYTE_W-1:0] jmp,
    input logic              flag,
    input logic [BYTE_W-1:0] fetch,
    input logic [OUT_W-1:0]  out_vec
);
    op_t op_view;
    assign op_view = op_t'(fetch);

    // R1
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (ph != $past(ph)));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(ph) && $stable(jmp) && $stable(flag) && $stable(out_vec)));

    // R5
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_TWO) |=> $stable(out_vec));

    // R5
    single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(out_vec ^ $past(out_vec)) <= 1));

    // R6
    jump_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ONE) |=> $stable(jmp));

    // R8
    discard_write_chk: assert property (@(posedge clk) disable iff (rst)
        (step && ph == PH_ONE && op_view.bit_sel == DISCARD_IDX) |=> $stable(out_vec));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ph == PH_ONE && jmp == '0 && !flag && out_vec == '0));

    // R10
    shadow_dest_chk: assert property (@(posedge clk)
        (rst && ph == PH_TWO) |-> (fetch == '0));

endmodule

bind bitjump_ctrl bjc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .ph      (phase_q),
    .jmp     (jmp_q),
    .flag    (flag_q),
    .fetch   (fetch_byte),
    .out_vec (out_vec)
);

// File: tb/bitjump_ctrl_bench.sv
module bitjump_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic [7:0] in_vec = '0;
    logic [7:0] out_vec;
    logic       rom_we = 1'b0;
    logic [9:0] rom_waddr = '0;
    logic [7:0] rom_wdata = '0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // bench model
    logic [7:0] m_rom [0:1023];
    logic       m_ph;
    logic       m_flag;
    logic [7:0] m_jmp;
    logic [7:0] m_out;

    always #2 clk = ~clk;

    bitjump_ctrl u_bitjump_ctrl (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .in_vec    (in_vec),
        .out_vec   (out_vec),
        .rom_we    (rom_we),
        .rom_waddr (rom_waddr),
        .rom_wdata (rom_wdata)
    );

    task automatic model_edge();
        logic [7:0] b;
        logic [7:0] lines;
        if (rst) begin
            m_ph = 1'b0; m_flag = 1'b0; m_jmp = '0; m_out = '0;
        end else if (step) begin
            b = m_rom[{m_jmp, m_ph, m_flag}];
            if (!m_ph) begin
                lines = {m_out[6], m_out[5], in_vec[5:0]};
                m_flag = lines[b[2:0]];
                if (b[5:3] != 3'd7) m_out[b[5:3]] = b[6];
                m_ph = 1'b1;
            end else begin
                m_jmp = b;
                m_ph = 1'b0;
            end
        end
        if (rom_we) m_rom[rom_waddr] = rom_wdata;
    endtask

    // called at a negedge with inputs set; returns at the next negedge
    task automatic cyc();
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: out_vec=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [7:0] d);
        rom_we = 1'b1; rom_waddr = 10'(a); rom_wdata = d;
        cyc();
        rom_we = 1'b0;
    endtask

    task automatic slot(input int s, input logic [7:0] opf, input logic [7:0] opt,
                        input logic [7:0] df, input logic [7:0] dt);
        put(4*s + 0, opf);
        put(4*s + 1, opt);
        put(4*s + 2, df);
        put(4*s + 3, dt);
    endtask

    task automatic restart();
        rst = 1'b1; step = 1'b1;
        run(2);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1; step = 1'b1;
        run(2);
        chk("R10 reset state", out_vec, 8'h00);

        // clear store (R11 write port)
        for (int a = 0; a < 1024; a++) put(a, 8'h00);

        // copy in0 -> out0
        slot(0, 8'h38, 8'h38, 8'd1, 8'd2);
        slot(1, 8'h00, 8'h00, 8'd0, 8'd0);
        slot(2, 8'h40, 8'h40, 8'd0, 8'd0);
        in_vec = 8'h01;
        restart();
        run(2);
        chk("R1 no write before third step", out_vec, 8'h00);
        run(1);
        chk("R1 R6 write at third step", out_vec, 8'h01);
        run(12);
        chk("R4 R11 copy in0=1", out_vec, 8'h01);
        in_vec = 8'h00;
        run(12);
        chk("R4 copy in0=0", out_vec, 8'h00);
        step = 1'b0; in_vec = 8'h01;
        run(10);
        chk("R2 stalled", out_vec, 8'h00);
        step = 1'b1;
        run(10);
        chk("R2 resumed", out_vec, 8'h01);

        // loopback: set out5, test line 6
        slot(0, 8'h68, 8'h68, 8'd3, 8'd3);
        slot(3, 8'h7E, 8'h7E, 8'd4, 8'd5);
        slot(4, 8'h50, 8'h50, 8'd4, 8'd4);
        slot(5, 8'h48, 8'h48, 8'd5, 8'd5);
        in_vec = 8'h80;
        restart();
        run(14);
        chk("R9 line6 reads out5", out_vec, 8'h22);
        // test line 7 (out6=0) with in_vec[7]=1 ignored
        slot(3, 8'h7F, 8'h7F, 8'd4, 8'd5);
        in_vec = 8'hC0;
        restart();
        run(14);
        chk("R9 line7 reads out6, in_vec[7] ignored", out_vec, 8'h24);

        // flag picks the op-byte variant
        slot(0, 8'h38, 8'h38, 8'd6, 8'd6);
        slot(6, 8'h58, 8'h60, 8'd6, 8'd6);
        in_vec = 8'h01;
        restart();
        run(12);
        chk("R7 R3 true variant", out_vec, 8'h10);
        run(1);
        rst = 1'b1;
        run(3);
        chk("R10 mid-run reset clears", out_vec, 8'h00);
        rst = 1'b0; in_vec = 8'h00;
        run(12);
        chk("R7 R3 false variant", out_vec, 8'h08);

        // discard slot
        slot(0, 8'h78, 8'h78, 8'd0, 8'd0);
        restart();
        run(10);
        chk("R8 discard write value 1", out_vec, 8'h00);
        slot(0, 8'h40, 8'h40, 8'd7, 8'd7);
        slot(7, 8'h78, 8'h78, 8'd7, 8'd7);
        restart();
        run(10);
        chk("R8 out bit7 stays 0", out_vec, 8'h01);

        // near-exhaustive sweep over random programs
        for (int p = 0; p < 3; p++) begin
            rst = 1'b1; step = 1'b1;
            for (int a = 0; a < 1024; a++) put(a, 8'($urandom));
            rst = 1'b0;
            for (int c = 0; c < 1500; c++) begin
                in_vec = 8'($urandom);
                step   = ($urandom % 4) != 0;
                rst    = ($urandom % 200) == 0;
                rom_we = ($urandom % 50) == 0;
                rom_waddr = 10'($urandom);
                rom_wdata = 8'($urandom);
                cyc();
                chk("sweep R3 R5 R6 R7 R9 R10 R11", out_vec, m_out);
            end
            rom_we = 1'b0; rst = 1'b0;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule